// File: doc/BRIEF.md
# Wiper Position Counter with Bus-Clocked Stepping

This block holds the tap position of one digitally controlled resistor ladder. A 6-bit count selects one of 64 tap switches: one at each end of the ladder and one between each pair of its 63 segments. The count is decoded into a registered one-hot vector of switch enables, so exactly one tap conducts at any time, even while the count is changing.

The command controller can load the count directly, for example with a host value or a value recalled from a stored setting. After the controller has acknowledged a step command, it raises `incdec_arm_i`. From then on, each rising edge of the bus clock `scl_i` moves the wiper one step. The level of `sda_i` at that edge sets the direction: high moves toward the high terminal (count up), low moves toward the low terminal (count down). Stepping stops at either end and never wraps. The mode stays active until the bus front end reports a stop or a start condition. `scl_i` and `sda_i` are expected to be already synchronised to `clk_i`. The start and stop indications are single-cycle pulses.

Top module: `wiper_stepper`

## Requirements
- R1: After reset the count is 0, only `tap_en_o[0]` is set, and step mode is inactive.
- R2: When `load_en_i` is high, the count equals `load_val_i` after the next clock edge.
- R3: While step mode is active, a rising edge of `scl_i` (low in the previous cycle, high now) with `sda_i` high raises the count by exactly one. Holding `scl_i` high does not step again.
- R4: While step mode is active, a rising edge of `scl_i` with `sda_i` low lowers the count by exactly one.
- R5: A step up at count 63 leaves the count at 63.
- R6: A step down at count 0 leaves the count at 0.
- R7: While step mode is inactive, edges on `scl_i` leave the count unchanged.
- R8: A pulse on `stop_det_i` makes step mode inactive after the next clock edge.
- R9: A pulse on `start_det_i` makes step mode inactive after the next clock edge.
- R10: If a load and a step request occur in the same cycle, the load wins.
- R11: `tap_en_o` always has exactly one bit set, at the index equal to `count_o`. It changes on the same clock edge as the count.
- R12: A pulse on `incdec_arm_i` makes step mode active after the next clock edge. If it coincides with a start or stop pulse, the mode ends up inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised bus clock level |
| sda_i | input | 1 | Synchronised bus data level (step direction) |
| start_det_i | input | 1 | Start condition seen (pulse) |
| stop_det_i | input | 1 | Stop condition seen (pulse) |
| incdec_arm_i | input | 1 | Step command acknowledged (pulse) |
| load_en_i | input | 1 | Parallel load strobe |
| load_val_i | input | 6 | Value to load into the count |
| count_o | output | 6 | Current wiper position |
| tap_en_o | output | 64 | One-hot tap switch enables |
| incdec_active_o | output | 1 | Step mode active |

## Verification
A corrupted count shows up at both `count_o` and `tap_en_o` on the very next sample after the faulty edge. A decode that drifts from the count shows as an enable bit at the wrong index, or as zero or two bits set. The bench compares both outputs against its own model after every cycle. A mode flag stuck high shows as a step after a stop or start, one cycle after the next `scl_i` rise. A missing saturation shows as a wrap to the opposite end on the first step past 63 or below 0.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'b00,
    STEP_UP   = 2'b01,
    STEP_DN   = 2'b10
  } step_e;
endpackage

// File: rtl/wiper_mode_ctl.sv
module wiper_mode_ctl
  import wiper_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  scl_i,
  input  logic  sda_i,
  input  logic  start_det_i,
  input  logic  stop_det_i,
  input  logic  arm_i,
  output logic  active_o,
  output step_e step_o
);
  logic scl_q, active_q, scl_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q    <= 1'b0;
      active_q <= 1'b0;
    end else begin
      scl_q <= scl_i;
      if (start_det_i || stop_det_i) active_q <= 1'b0;
      else if (arm_i)                active_q <= 1'b1;
    end
  end

  assign scl_rise = scl_i & ~scl_q;

  always_comb begin
    step_o = STEP_NONE;
    if (active_q && scl_rise) step_o = sda_i ? STEP_UP : STEP_DN;
  end

  assign active_o = active_q;
endmodule

// File: rtl/wiper_count.sv
module wiper_count
  import wiper_pkg::*;
#(
  parameter int unsigned POS_W   = 6,
  parameter int unsigned RST_POS = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_en_i,
  input  logic [POS_W-1:0] load_val_i,
  input  step_e            step_i,
  output logic [POS_W-1:0] cnt_next_o,
  output logic [POS_W-1:0] cnt_o
);
  localparam logic [POS_W-1:0] MaxPos = {POS_W{1'b1}};
  logic [POS_W-1:0] cnt_q;

  always_comb begin
    cnt_next_o = cnt_q;
    if (load_en_i)                                cnt_next_o = load_val_i;
    else if (step_i == STEP_UP && cnt_q != MaxPos) cnt_next_o = cnt_q + 1'b1;
    else if (step_i == STEP_DN && cnt_q != '0)     cnt_next_o = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= POS_W'(RST_POS);
    else         cnt_q <= cnt_next_o;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tap_decode.sv
module tap_decode #(
  parameter int unsigned TAPS    = 64,
  parameter int unsigned RST_POS = 0,
  localparam int unsigned POS_W  = $clog2(TAPS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [POS_W-1:0] cnt_next_i,
  output logic [TAPS-1:0]  tap_en_o
);
  logic [TAPS-1:0] dec;
  logic [TAPS-1:0] tap_q;

  for (genvar g = 0; g < TAPS; g++) begin : g_tap
    assign dec[g] = (cnt_next_i == POS_W'(g));
  end

  // decode the next count so enables switch on the same edge as the count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tap_q <= TAPS'(1) << RST_POS;
    else         tap_q <= dec;
  end

  assign tap_en_o = tap_q;
endmodule

// File: rtl/wiper_stepper.sv
module wiper_stepper
  import wiper_pkg::*;
#(
  parameter int unsigned TAPS    = 64,
  parameter int unsigned RST_POS = 0,
  localparam int unsigned POS_W  = $clog2(TAPS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             start_det_i,
  input  logic             stop_det_i,
  input  logic             incdec_arm_i,
  input  logic             load_en_i,
  input  logic [POS_W-1:0] load_val_i,
  output logic [POS_W-1:0] count_o,
  output logic [TAPS-1:0]  tap_en_o,
  output logic             incdec_active_o
);
  step_e            step;
  logic [POS_W-1:0] cnt_next;

  wiper_mode_ctl u_mode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .scl_i       (scl_i),
    .sda_i       (sda_i),
    .start_det_i (start_det_i),
    .stop_det_i  (stop_det_i),
    .arm_i       (incdec_arm_i),
    .active_o    (incdec_active_o),
    .step_o      (step)
  );

  wiper_count #(.POS_W(POS_W), .RST_POS(RST_POS)) u_count (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_en_i  (load_en_i),
    .load_val_i (load_val_i),
    .step_i     (step),
    .cnt_next_o (cnt_next),
    .cnt_o      (count_o)
  );

  tap_decode #(.TAPS(TAPS), .RST_POS(RST_POS)) u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_next_i (cnt_next),
    .tap_en_o   (tap_en_o)
  );
endmodule

// File: rtl/wiper_stepper_chk.sv
module wiper_stepper_chk #(
  parameter int unsigned TAPS    = 64,
  localparam int unsigned POS_W  = $clog2(TAPS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_det_i,
  input logic             stop_det_i,
  input logic             load_en_i,
  input logic [POS_W-1:0] load_val_i,
  input logic [POS_W-1:0] count_o,
  input logic [TAPS-1:0]  tap_en_o,
  input logic             incdec_active_o
);
  localparam logic [POS_W-1:0] MaxPos = {POS_W{1'b1}};

  a_r11_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(tap_en_o) && tap_en_o[count_o]);

  a_r2_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_en_i |=> count_o == $past(load_val_i));

  a_r3_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_en_i |=> (count_o == $past(count_o)) || (count_o == $past(count_o) + 1'b1)
                   || ($past(count_o) == count_o + 1'b1));

  a_r5_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == MaxPos && !load_en_i) |=> count_o != '0);

  a_r6_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == '0 && !load_en_i) |=> count_o != MaxPos);

  a_r7_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!incdec_active_o && !load_en_i) |=> $stable(count_o));

  a_r8_r9_mode_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_det_i || stop_det_i) |=> !incdec_active_o);
endmodule

bind wiper_stepper wiper_stepper_chk #(.TAPS(TAPS)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .start_det_i     (start_det_i),
  .stop_det_i      (stop_det_i),
  .load_en_i       (load_en_i),
  .load_val_i      (load_val_i),
  .count_o         (count_o),
  .tap_en_o        (tap_en_o),
  .incdec_active_o (incdec_active_o)
);

// File: tb/wiper_stepper_bench.sv
module wiper_stepper_bench;
  localparam int TAPS = 64;
  localparam int W    = 6;

  logic clk = 0, rst_n = 0;
  logic scl = 0, sda = 0, start_d = 0, stop_d = 0, arm = 0, ld = 0;
  logic [W-1:0]    ld_val = '0;
  logic [W-1:0]    cnt;
  logic [TAPS-1:0] tap;
  logic            act;

  always #10 clk = ~clk;

  wiper_stepper u_wiper_stepper (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda),
    .start_det_i(start_d), .stop_det_i(stop_d), .incdec_arm_i(arm),
    .load_en_i(ld), .load_val_i(ld_val), .count_o(cnt), .tap_en_o(tap),
    .incdec_active_o(act)
  );

  typedef struct { string tag; int count; bit active; } item_t;
  item_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  int  m_cnt = 0;
  bit  m_act = 0, m_scl = 0;

  task automatic check(string tag, int ec, bit ea);
    logic [TAPS-1:0] et;
    et = TAPS'(1) << ec;
    checks++;
    if (cnt !== W'(ec) || tap !== et || act !== ea) begin
      fails++;
      $display("FAIL %s: count=%0d tap=%h active=%0b expected count=%0d tap=%h active=%0b",
               tag, cnt, tap, act, ec, et, ea);
    end
  endtask

  // monitor: compare queued expectations away from the active edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check(it.tag, it.count, it.active);
    end
  end

  task automatic cyc(string tag, bit s_scl, bit s_sda, bit s_arm, bit s_start,
                     bit s_stop, bit s_ld, int s_val);
    bit rise;
    item_t it;
    @(negedge clk);
    scl = s_scl; sda = s_sda; arm = s_arm; start_d = s_start; stop_d = s_stop;
    ld = s_ld; ld_val = W'(s_val);
    rise = s_scl && !m_scl;
    if (s_ld) m_cnt = s_val;
    else if (m_act && rise && s_sda && m_cnt < TAPS-1) m_cnt++;
    else if (m_act && rise && !s_sda && m_cnt > 0) m_cnt--;
    if (s_start || s_stop) m_act = 0;
    else if (s_arm) m_act = 1;
    m_scl = s_scl;
    @(posedge clk); #2;
    it.tag = tag; it.count = m_cnt; it.active = m_act;
    q.push_back(it);
  endtask

  task automatic idle(string tag);
    cyc(tag, 0, sda, 0, 0, 0, 0, 0);
  endtask

  task automatic pulse(string tag, bit dir);
    cyc(tag, 1, dir, 0, 0, 0, 0, 0);
    cyc(tag, 0, dir, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    end
    $finish;
  end

  initial begin
    #45;
    check("R1 reset", 0, 0);
    rst_n = 1;
    idle("R1 idle");
    // R7: pulses before arming are ignored
    pulse("R7 idle up", 1);
    pulse("R7 idle dn", 0);
    cyc("R12 arm", 0, 0, 1, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) pulse("R3 up", 1);
    // R3: a held-high scl gives one step only
    cyc("R3 hold", 1, 1, 0, 0, 0, 0, 0);
    cyc("R3 hold", 1, 1, 0, 0, 0, 0, 0);
    cyc("R3 hold", 1, 0, 0, 0, 0, 0, 0);
    idle("R3 release");
    for (int i = 0; i < 2; i++) pulse("R4 down", 0);
    cyc("R2 load", 0, 0, 0, 0, 0, 1, 62);
    for (int i = 0; i < 3; i++) pulse("R5 saturate high", 1);
    cyc("R2 load", 0, 0, 0, 0, 0, 1, 1);
    for (int i = 0; i < 3; i++) pulse("R6 saturate low", 0);
    cyc("R2 load mid", 0, 0, 0, 0, 0, 1, 37);
    cyc("R10 load vs step", 1, 1, 0, 0, 0, 1, 20);
    idle("R10 after");
    pulse("R11 step", 1);
    cyc("R8 stop", 0, 0, 0, 0, 1, 0, 0);
    pulse("R8 ignored up", 1);
    pulse("R8 ignored dn", 0);
    cyc("R12 rearm", 0, 0, 1, 0, 0, 0, 0);
    pulse("R11 step", 0);
    cyc("R9 start", 0, 0, 0, 1, 0, 0, 0);
    pulse("R9 ignored", 1);
    cyc("R12 arm with stop", 0, 0, 1, 0, 1, 0, 0);
    pulse("R12 ignored", 1);
    for (int v = 0; v < TAPS; v += 9) cyc("R11 decode", 0, 0, 0, 0, 0, 1, v);
    cyc("R11 decode top", 0, 0, 0, 0, 0, 1, TAPS-1);
    idle("end");
    @(negedge clk); @(negedge clk);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    end
    $finish;
  end
endmodule